// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block turns one operand specifier into the address a load/store unit should use. Each request carries four things: a mode code, the operand size, the values of the base register, the index register and the program counter, and a 16-bit signed displacement. It also carries the number of the base register. The block answers with the effective address and a flag that says whether memory is touched at all. A second flag marks an operand that lives in a register. When the mode changes the pointer register, the block also returns the new pointer value and that register's number on a write-back port.

Requests and responses use valid/ready handshakes, with one response for every accepted request. The response is registered and appears the cycle after acceptance. It is held unchanged while the consumer stalls, and a new request is taken in the same cycle that a held response drains. The displacement is sign-extended to the address width, and all sums wrap modulo 2^32.

The pointer step for the auto-modify modes comes from the size code: 1 for byte, 2 for halfword, 4 for word. Memory-indirect fetch, the memory itself and instruction decode sit outside this block.

Top module: `eaGen`

## Requirements
- R1: A request is accepted when reqValid and reqReady are both high. reqReady is high whenever no response is held or rspReady is high. rspValid rises the cycle after acceptance, and the response stays unchanged while rspReady is low.
- R2: After reset, rspValid and wbEn are low and reqReady is high.
- R3: Mode 0 (immediate) gives memAccess=0, regOperand=0, eaAddr=0 and no write-back.
- R4: Mode 1 (register operand) gives regOperand=1, memAccess=0 and eaAddr=0. memAccess and regOperand are never both high.
- R5: Mode 2 (absolute) gives eaAddr = sign-extended displacement, with memAccess=1.
- R6: Mode 3 (register indirect) gives eaAddr = baseVal, with memAccess=1.
- R7: Mode 4 (indexed) gives eaAddr = baseVal + sign-extended displacement, modulo 2^32. Example: base 1200 with displacement 20 gives 1220.
- R8: Mode 5 gives baseVal + indexVal. Mode 6 adds the sign-extended displacement to that sum. Example: 1200 + 4600 with displacement 30 gives 5830.
- R9: Mode 7 (PC-relative) gives eaAddr = pcVal + sign-extended displacement.
- R10: Mode 8 (post-increment) gives eaAddr = baseVal, wbEn=1 and wbData = baseVal + step.
- R11: Mode 9 (pre-decrement) gives eaAddr = wbData = baseVal - step, with wbEn=1.
- R12: The step is set by opSize: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R13: Mode codes 10 to 15 give rspError=1, memAccess=0, regOperand=0, eaAddr=0 and wbEn=0.
- R14: wbEn is high only for modes 8 and 9, and only while rspValid is high. wbSel then equals the baseSel of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| mode | input | 4 | Addressing mode code |
| opSize | input | 2 | Operand size code (sets the step) |
| baseSel | input | 5 | Number of the base register |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register value |
| pcVal | input | 32 | Program counter value |
| disp | input | 16 | Signed displacement |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Consumer takes the response |
| eaAddr | output | 32 | Effective address |
| memAccess | output | 1 | Operand is in memory |
| regOperand | output | 1 | Operand is a register |
| rspError | output | 1 | Mode code is illegal |
| wbEn | output | 1 | Pointer write-back is requested |
| wbSel | output | 5 | Register to be written back |
| wbData | output | 32 | Updated pointer value |

## Verification
Two things can land in the same response cycle: an auto-modify response carries both an address and a write-back, and these must agree in the order the mode implies (old pointer for post-increment, new pointer for pre-decrement). A stalled response can also drain in the same cycle that the next request is accepted.

The first case is provoked by random post-increment and pre-decrement requests at every size. The second is provoked by holding rspReady low while a second request waits, then releasing it. Both are judged against a bench-side model of each mode, and the held response must not change during the stall.

// File: rtl/eaGenPkg.sv
package eaGenPkg;

  typedef enum logic [3:0] {
    MODE_IMM      = 4'd0,
    MODE_REG      = 4'd1,
    MODE_ABS      = 4'd2,
    MODE_REG_IND  = 4'd3,
    MODE_INDEXED  = 4'd4,
    MODE_BASE_IDX = 4'd5,
    MODE_BIX_OFF  = 4'd6,
    MODE_PC_REL   = 4'd7,
    MODE_POST_INC = 4'd8,
    MODE_PRE_DEC  = 4'd9
  } eaMode_e;

  typedef enum logic [1:0] {
    OPA_ZERO = 2'd0,
    OPA_BASE = 2'd1,
    OPA_PC   = 2'd2
  } opASel_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } stepOp_e;

  typedef enum logic [1:0] {
    ADDR_ZERO = 2'd0,
    ADDR_SUM  = 2'd1,
    ADDR_BASE = 2'd2
  } addrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    opASel_e  opASel;
    logic     addIndex;
    logic     addDisp;
    stepOp_e  stepOp;
    addrSel_e addrSel;
  } eaStrobe_t;

endpackage

// File: rtl/eaCtrl.sv
module eaCtrl
  import eaGenPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [3:0] mode,
  output logic       rspValid,
  input  logic       rspReady,
  output logic       memAccess,
  output logic       regOperand,
  output logic       rspError,
  output logic       wbEn,
  output eaStrobe_t  strobe
);

  logic accept;
  logic decMem, decReg, decErr, decWb;
  eaStrobe_t decStrobe;

  assign reqReady = !rspValid || rspReady;
  assign accept   = reqValid && reqReady;

  always_comb begin
    decStrobe         = '0;
    decStrobe.opASel  = OPA_ZERO;
    decStrobe.stepOp  = STEP_NONE;
    decStrobe.addrSel = ADDR_ZERO;
    decMem = 1'b0;
    decReg = 1'b0;
    decErr = 1'b0;
    decWb  = 1'b0;
    case (mode)
      MODE_IMM: ;
      MODE_REG: decReg = 1'b1;
      MODE_ABS: begin
        decMem = 1'b1;
        decStrobe.addDisp = 1'b1;
        decStrobe.addrSel = ADDR_SUM;
      end
      MODE_REG_IND: begin
        decMem = 1'b1;
        decStrobe.addrSel = ADDR_BASE;
      end
      MODE_INDEXED: begin
        decMem = 1'b1;
        decStrobe.opASel  = OPA_BASE;
        decStrobe.addDisp = 1'b1;
        decStrobe.addrSel = ADDR_SUM;
      end
      MODE_BASE_IDX: begin
        decMem = 1'b1;
        decStrobe.opASel   = OPA_BASE;
        decStrobe.addIndex = 1'b1;
        decStrobe.addrSel  = ADDR_SUM;
      end
      MODE_BIX_OFF: begin
        decMem = 1'b1;
        decStrobe.opASel   = OPA_BASE;
        decStrobe.addIndex = 1'b1;
        decStrobe.addDisp  = 1'b1;
        decStrobe.addrSel  = ADDR_SUM;
      end
      MODE_PC_REL: begin
        decMem = 1'b1;
        decStrobe.opASel  = OPA_PC;
        decStrobe.addDisp = 1'b1;
        decStrobe.addrSel = ADDR_SUM;
      end
      MODE_POST_INC: begin
        decMem = 1'b1;
        decWb  = 1'b1;
        decStrobe.opASel  = OPA_BASE;
        decStrobe.stepOp  = STEP_UP;
        decStrobe.addrSel = ADDR_BASE;
      end
      MODE_PRE_DEC: begin
        decMem = 1'b1;
        decWb  = 1'b1;
        decStrobe.opASel  = OPA_BASE;
        decStrobe.stepOp  = STEP_DOWN;
        decStrobe.addrSel = ADDR_SUM;
      end
      default: decErr = 1'b1;
    endcase
    decStrobe.load = accept;
  end

  assign strobe = decStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      memAccess  <= 1'b0;
      regOperand <= 1'b0;
      rspError   <= 1'b0;
      wbEn       <= 1'b0;
    end else if (accept) begin
      rspValid   <= 1'b1;
      memAccess  <= decMem;
      regOperand <= decReg;
      rspError   <= decErr;
      wbEn       <= decWb;
    end else if (rspReady) begin
      rspValid   <= 1'b0;
      memAccess  <= 1'b0;
      regOperand <= 1'b0;
      rspError   <= 1'b0;
      wbEn       <= 1'b0;
    end
  end

endmodule

// File: rtl/eaDatapath.sv
module eaDatapath
  import eaGenPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int RSEL_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  eaStrobe_t         strobe,
  input  logic [1:0]        opSize,
  input  logic [RSEL_W-1:0] baseSel,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] pcVal,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] eaAddr,
  output logic [RSEL_W-1:0] wbSel,
  output logic [ADDR_W-1:0] wbData
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] dispExt, opA, opB, opC, stepVal, stepTerm, sum, addrNext;

  generate
    if (EXT_W > 0) begin : gExt
      assign dispExt = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : gNoExt
      assign dispExt = disp[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    case (opSize)
      2'd0:    stepVal = ADDR_W'(1);
      2'd1:    stepVal = ADDR_W'(2);
      default: stepVal = ADDR_W'(4);
    endcase
    case (strobe.stepOp)
      STEP_UP:   stepTerm = stepVal;
      STEP_DOWN: stepTerm = ~stepVal + ADDR_W'(1);
      default:   stepTerm = '0;
    endcase
    case (strobe.opASel)
      OPA_BASE: opA = baseVal;
      OPA_PC:   opA = pcVal;
      default:  opA = '0;
    endcase
    opB = strobe.addIndex ? indexVal : '0;
    opC = strobe.addDisp ? dispExt : '0;
    sum = opA + opB + opC + stepTerm;
    case (strobe.addrSel)
      ADDR_SUM:  addrNext = sum;
      ADDR_BASE: addrNext = baseVal;
      default:   addrNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaAddr <= '0;
      wbSel  <= '0;
      wbData <= '0;
    end else if (strobe.load) begin
      eaAddr <= addrNext;
      wbSel  <= baseSel;
      wbData <= sum;
    end
  end

endmodule

// File: rtl/eaGen.sv
module eaGen
  import eaGenPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int RSEL_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [3:0]        mode,
  input  logic [1:0]        opSize,
  input  logic [RSEL_W-1:0] baseSel,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] pcVal,
  input  logic [DISP_W-1:0] disp,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] eaAddr,
  output logic              memAccess,
  output logic              regOperand,
  output logic              rspError,
  output logic              wbEn,
  output logic [RSEL_W-1:0] wbSel,
  output logic [ADDR_W-1:0] wbData
);

  eaStrobe_t strobe;

  eaCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .mode(mode), .rspValid(rspValid), .rspReady(rspReady),
    .memAccess(memAccess), .regOperand(regOperand), .rspError(rspError),
    .wbEn(wbEn), .strobe(strobe)
  );

  eaDatapath #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .RSEL_W(RSEL_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opSize(opSize),
    .baseSel(baseSel), .baseVal(baseVal), .indexVal(indexVal),
    .pcVal(pcVal), .disp(disp), .eaAddr(eaAddr), .wbSel(wbSel),
    .wbData(wbData)
  );

endmodule

// File: rtl/eaGenChk.sv
module eaGenChk #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int RSEL_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [3:0]        mode,
  input logic [1:0]        opSize,
  input logic [RSEL_W-1:0] baseSel,
  input logic [ADDR_W-1:0] baseVal,
  input logic              rspValid,
  input logic              rspReady,
  input logic [ADDR_W-1:0] eaAddr,
  input logic              memAccess,
  input logic              regOperand,
  input logic              rspError,
  input logic              wbEn,
  input logic [RSEL_W-1:0] wbSel,
  input logic [ADDR_W-1:0] wbData
);

  logic              tookReq;
  logic [3:0]        tookMode;
  logic [ADDR_W-1:0] tookBase;
  logic [ADDR_W-1:0] tookStep;
  logic [RSEL_W-1:0] tookSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tookReq  <= 1'b0;
      tookMode <= '0;
      tookBase <= '0;
      tookStep <= '0;
      tookSel  <= '0;
    end else begin
      tookReq <= reqValid && reqReady;
      if (reqValid && reqReady) begin
        tookMode <= mode;
        tookBase <= baseVal;
        tookStep <= (opSize == 2'd0) ? ADDR_W'(1) : (opSize == 2'd1) ? ADDR_W'(2) : ADDR_W'(4);
        tookSel  <= baseSel;
      end
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(eaAddr) && $stable(wbEn) && $stable(wbData)));

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(memAccess && regOperand));

  assert_postinc_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tookReq && tookMode == 4'd8) |-> (eaAddr == tookBase && wbEn && wbData == tookBase + tookStep));

  assert_predec_R11: assert property (@(posedge clk) disable iff (!rstN)
    (tookReq && tookMode == 4'd9) |-> (eaAddr == wbData && wbEn && wbData == tookBase - tookStep));

  assert_illegal_R13: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspError) |-> (!wbEn && !memAccess));

  assert_wbvalid_R14: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> rspValid);

  assert_wbsel_R14: assert property (@(posedge clk) disable iff (!rstN)
    (tookReq && wbEn) |-> (wbSel == tookSel));

endmodule

bind eaGen eaGenChk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .RSEL_W(RSEL_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .mode(mode), .opSize(opSize), .baseSel(baseSel), .baseVal(baseVal),
  .rspValid(rspValid), .rspReady(rspReady), .eaAddr(eaAddr),
  .memAccess(memAccess), .regOperand(regOperand), .rspError(rspError),
  .wbEn(wbEn), .wbSel(wbSel), .wbData(wbData)
);

// File: tb/tb_eaGen.sv
`timescale 1ns/1ps
module tb_eaGen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  mode = '0;
  logic [1:0]  opSize = '0;
  logic [4:0]  baseSel = '0;
  logic [31:0] baseVal = '0, indexVal = '0, pcVal = '0;
  logic [15:0] disp = '0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic [31:0] eaAddr, wbData;
  logic        memAccess, regOperand, rspError, wbEn;
  logic [4:0]  wbSel;

  int nTot = 0;
  int nFail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  eaGen dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .mode(mode), .opSize(opSize), .baseSel(baseSel), .baseVal(baseVal),
    .indexVal(indexVal), .pcVal(pcVal), .disp(disp), .rspValid(rspValid),
    .rspReady(rspReady), .eaAddr(eaAddr), .memAccess(memAccess),
    .regOperand(regOperand), .rspError(rspError), .wbEn(wbEn),
    .wbSel(wbSel), .wbData(wbData)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTot++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [3:0] m);
    case (m)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5, 4'd6: return "R8";
      4'd7: return "R9";
      4'd8: return "R10";
      4'd9: return "R11";
      default: return "R13";
    endcase
  endfunction

  // independent model of the requirements
  task automatic model(input logic [3:0] m, input logic [1:0] sz,
                       input logic [31:0] b, input logic [31:0] x,
                       input logic [31:0] p, input logic [15:0] d,
                       output logic [31:0] eAddr, output logic eMem,
                       output logic eReg, output logic eErr, output logic eWb,
                       output logic [31:0] eWbData);
    logic [31:0] dx, st;
    dx = {{16{d[15]}}, d};
    st = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4; // R12
    eAddr = 32'd0; eMem = 1'b0; eReg = 1'b0; eErr = 1'b0; eWb = 1'b0; eWbData = 32'd0;
    case (m)
      4'd0: ;
      4'd1: eReg = 1'b1;
      4'd2: begin eMem = 1'b1; eAddr = dx; end
      4'd3: begin eMem = 1'b1; eAddr = b; end
      4'd4: begin eMem = 1'b1; eAddr = b + dx; end
      4'd5: begin eMem = 1'b1; eAddr = b + x; end
      4'd6: begin eMem = 1'b1; eAddr = b + x + dx; end
      4'd7: begin eMem = 1'b1; eAddr = p + dx; end
      4'd8: begin eMem = 1'b1; eAddr = b; eWb = 1'b1; eWbData = b + st; end
      4'd9: begin eMem = 1'b1; eAddr = b - st; eWb = 1'b1; eWbData = b - st; end
      default: eErr = 1'b1;
    endcase
  endtask

  task automatic checkRsp(input logic [3:0] m, input logic [1:0] sz,
                          input logic [4:0] sel, input logic [31:0] b,
                          input logic [31:0] x, input logic [31:0] p,
                          input logic [15:0] d);
    logic [31:0] eAddr, eWbData;
    logic eMem, eReg, eErr, eWb;
    string t;
    model(m, sz, b, x, p, d, eAddr, eMem, eReg, eErr, eWb, eWbData);
    t = tagOf(m);
    chk(rspValid === 1'b1, "R1", "rspValid", {31'd0, rspValid}, 32'd1);
    chk(eaAddr === eAddr, t, "eaAddr", eaAddr, eAddr);
    chk(memAccess === eMem, t, "memAccess", {31'd0, memAccess}, {31'd0, eMem});
    chk(regOperand === eReg, t, "regOperand", {31'd0, regOperand}, {31'd0, eReg});
    chk(rspError === eErr, t, "rspError", {31'd0, rspError}, {31'd0, eErr});
    chk(wbEn === eWb, "R14", "wbEn", {31'd0, wbEn}, {31'd0, eWb});
    if (eWb) begin
      chk(wbData === eWbData, "R12", "wbData", wbData, eWbData);
      chk(wbSel === sel, "R14", "wbSel", {27'd0, wbSel}, {27'd0, sel});
    end
  endtask

  task automatic drive(input logic [3:0] m, input logic [1:0] sz,
                       input logic [4:0] sel, input logic [31:0] b,
                       input logic [31:0] x, input logic [31:0] p,
                       input logic [15:0] d);
    mode = m; opSize = sz; baseSel = sel; baseVal = b;
    indexVal = x; pcVal = p; disp = d;
  endtask

  task automatic one(input logic [3:0] m, input logic [1:0] sz,
                     input logic [4:0] sel, input logic [31:0] b,
                     input logic [31:0] x, input logic [31:0] p,
                     input logic [15:0] d);
    @(negedge clk);
    drive(m, sz, sel, b, x, p, d);
    reqValid = 1'b1;
    rspReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp(m, sz, sel, b, x, p, d);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nTot++;
        nFail++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("%0d/%0d checks passed", nTot - nFail, nTot);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [31:0] h0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(rspValid === 1'b0, "R2", "rspValid", {31'd0, rspValid}, 32'd0);
    chk(wbEn === 1'b0, "R2", "wbEn", {31'd0, wbEn}, 32'd0);
    chk(reqReady === 1'b1, "R2", "reqReady", {31'd0, reqReady}, 32'd1);

    // directed corner cases
    one(4'd4, 2'd2, 5'd1, 32'd1200, 32'd0, 32'd0, 16'd20);            // R7 1220
    one(4'd6, 2'd2, 5'd1, 32'd1200, 32'd4600, 32'd0, 16'd30);         // R8 5830
    one(4'd5, 2'd2, 5'd1, 32'd1200, 32'd4600, 32'd0, 16'd30);         // R8
    one(4'd0, 2'd2, 5'd3, 32'h1234, 32'h55, 32'h99, 16'h7fff);        // R3
    one(4'd1, 2'd2, 5'd3, 32'h1234, 32'h55, 32'h99, 16'h7fff);        // R4
    one(4'd2, 2'd0, 5'd3, 32'h1234, 32'h55, 32'h99, 16'h8000);        // R5 sign ext
    one(4'd3, 2'd0, 5'd3, 32'hdead_beef, 32'h55, 32'h99, 16'h1);      // R6
    one(4'd7, 2'd1, 5'd3, 32'h0, 32'h0, 32'h0000_0010, 16'hfff0);     // R9 backwards
    one(4'd4, 2'd1, 5'd3, 32'hffff_fffc, 32'h0, 32'h0, 16'd8);        // R7 wrap
    one(4'd8, 2'd0, 5'd7, 32'd100, 32'h0, 32'h0, 16'd0);              // R10 step 1
    one(4'd8, 2'd1, 5'd7, 32'd100, 32'h0, 32'h0, 16'd0);              // R12 step 2
    one(4'd8, 2'd3, 5'd7, 32'hffff_fffe, 32'h0, 32'h0, 16'd0);        // R12 code3 -> 4, wrap
    one(4'd9, 2'd2, 5'd9, 32'd100, 32'h0, 32'h0, 16'd0);              // R11
    one(4'd9, 2'd0, 5'd9, 32'd0, 32'h0, 32'h0, 16'd0);                // R11 wrap below 0
    one(4'd10, 2'd2, 5'd9, 32'd100, 32'h0, 32'h0, 16'd4);             // R13
    one(4'd15, 2'd2, 5'd9, 32'd100, 32'h0, 32'h0, 16'd4);             // R13

    // R1 back-pressure: hold, then drain and accept in the same cycle
    @(negedge clk);
    drive(4'd8, 2'd2, 5'd4, 32'h1000, 32'h0, 32'h0, 16'd0);
    reqValid = 1'b1;
    rspReady = 1'b0;
    @(posedge clk);
    @(negedge clk);
    h0 = eaAddr;
    drive(4'd9, 2'd1, 5'd6, 32'h2000, 32'h0, 32'h0, 16'd0);
    chk(reqReady === 1'b0, "R1", "reqReady while held", {31'd0, reqReady}, 32'd0);
    checkRsp(4'd8, 2'd2, 5'd4, 32'h1000, 32'h0, 32'h0, 16'd0);
    @(posedge clk);
    @(negedge clk);
    chk(eaAddr === h0, "R1", "held eaAddr", eaAddr, h0);
    checkRsp(4'd8, 2'd2, 5'd4, 32'h1000, 32'h0, 32'h0, 16'd0);
    rspReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp(4'd9, 2'd1, 5'd6, 32'h2000, 32'h0, 32'h0, 16'd0);
    @(posedge clk);
    @(negedge clk);
    chk(rspValid === 1'b0, "R1", "drained rspValid", {31'd0, rspValid}, 32'd0);
    chk(wbEn === 1'b0, "R14", "wbEn after drain", {31'd0, wbEn}, 32'd0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] m;
      m = (($urandom % 8) == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
      one(m, 2'($urandom), 5'($urandom), $urandom, $urandom, $urandom, 16'($urandom));
    end

    $display("%0d/%0d checks passed", nTot - nFail, nTot);
    $finish;
  end

endmodule